// File: doc/BRIEF.md
# Dual-Mode General-Purpose Timer

A 32-bit up-counter with a register port, used as a general-purpose timer by software. A processor programs a reload value, a compare value and a control word, then starts the counter. The counter advances on a clock-enable tick. Each tick can first pass through a power-of-two divider. When the counter passes its all-ones value, it either restarts from the reload value or halts. On the way it raises status flags for overflow, compare match and input capture. An interrupt line combines those flags with an enable mask.

Register writes are posted. A write enters a short pipeline and changes the register state two clock edges after the bus samples it. A pending flag stays readable the whole time, so software can poll it. A trigger register restarts the count from the reload value. A waveform output can toggle, or give a single-cycle pulse, on overflow alone or on overflow and match, with selectable polarity. An external input can capture the running count on a rising edge, a falling edge or both edges. It can either overwrite the capture on every edge or keep the first capture until software acknowledges it.

Reads are combinational from the bus address. Writes use `bus_wr` with the same address bus. Byte offsets: 0x00 identity, 0x18 status, 0x1C interrupt enable, 0x24 control, 0x28 count, 0x2C reload, 0x30 trigger, 0x34 write pending, 0x38 compare, 0x3C capture. Other offsets read zero and ignore writes.

Top module: `gp_timer`

## Requirements
- R1: After reset the control, count, status, enable and capture registers read 0, the pending register reads 0, `irq_out` and `pwm_out` are 0, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: A write sampled on clock edge E changes register state at edge E+2. Offset 0x34 reads 1 after edges E and E+1, and reads 0 after edge E+2 if no further write follows.
- R3: While control bit 0 (run) is 1 and `tick_en` is 1, each counting step adds one to the count. With run at 0 or `tick_en` at 0, the count holds.
- R4: When control bit 5 is 1, one counting step happens every 2^(P+1) ticks, where P is control bits 4:2. When bit 5 is 0, one step happens per tick.
- R5: A step taken at count 0xFFFFFFFF sets status bit 1. If control bit 1 is 1, the count becomes the reload value. Otherwise the count becomes 0 and control bit 0 clears.
- R6: When control bit 6 is 1, a step that brings the count to the compare value sets status bit 0. When bit 6 is 0, no match flag is raised.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq_out` is the OR over bits 2:0 of status ANDed with enable.
- R8: A write of any value to offset 0x30 loads the count from the reload register. A write to offset 0x28 sets the count directly.
- R9: Control bits 9:8 select the capture edge of `cap_in`: 00 none, 01 rising, 10 falling, 11 both. A selected edge sets status bit 2 and copies the count into the capture register.
- R10: When control bit 13 is 1, the capture register is not overwritten while status bit 2 is set. When bit 13 is 0, every selected edge overwrites it.
- R11: Control bits 11:10 select the waveform event: 01 overflow, 10 overflow or match, 00 or 11 none. Control bit 7 set makes each event toggle the waveform. Bit 7 clear makes the waveform high for the one cycle after the event. Control bit 12 inverts `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counting clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cap_in | input | 1 | Capture input, synchronous to `clk` |
| pwm_out | output | 1 | Waveform output |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench exercises the overflow boundary in both reload modes. It checks that, in the first cycle the interrupt shows, the count already equals the reload value or zero. A design that increments past all-ones, or keeps running in one-shot mode, fails there. It measures the divider over whole multiples of its period and probes the pending flag in each cycle of a posted write. This exposes a divider that is off by one and a write that lands one edge early or late. The capture tests apply the unselected edge and the hold mode, which a design that ignores the edge selection or always overwrites the capture would get wrong. The write-zero and enable-masking checks catch a status register that clears whole words or an interrupt that ignores its mask.

// File: rtl/gpt_pkg.sv
`timescale 1ns/1ps
// Shared offsets, control-field positions and types of the general-purpose timer.
// Assumes a byte-addressed 32-bit register port with 8-bit offsets.
package gpt_pkg;
    localparam int ADR_W  = 8;
    localparam int BUS_W  = 32;
    localparam int CTRL_W = 14;
    localparam int STAT_W = 3;

    localparam logic [ADR_W-1:0] A_ID    = 8'h00;
    localparam logic [ADR_W-1:0] A_STAT  = 8'h18;
    localparam logic [ADR_W-1:0] A_IEN   = 8'h1C;
    localparam logic [ADR_W-1:0] A_CTRL  = 8'h24;
    localparam logic [ADR_W-1:0] A_COUNT = 8'h28;
    localparam logic [ADR_W-1:0] A_RELD  = 8'h2C;
    localparam logic [ADR_W-1:0] A_TRIG  = 8'h30;
    localparam logic [ADR_W-1:0] A_PEND  = 8'h34;
    localparam logic [ADR_W-1:0] A_CMP   = 8'h38;
    localparam logic [ADR_W-1:0] A_CAPT  = 8'h3C;

    localparam int B_RUN  = 0;
    localparam int B_ARL  = 1;
    localparam int B_DIV  = 2;
    localparam int B_PREN = 5;
    localparam int B_CMPE = 6;
    localparam int B_TGL  = 7;
    localparam int B_EDGE = 8;
    localparam int B_WEVT = 10;
    localparam int B_INV  = 12;
    localparam int B_HOLD = 13;

    localparam int S_MATCH = 0;
    localparam int S_OVF   = 1;
    localparam int S_CAPT  = 2;

    typedef enum logic [1:0] {EDGE_NONE, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_sel_e;
    typedef enum logic [1:0] {WAVE_OFF, WAVE_OVF, WAVE_OVF_CMP, WAVE_RSVD} wave_sel_e;

    typedef struct packed {
        logic [ADR_W-1:0] addr;
        logic [BUS_W-1:0] data;
    } post_wr_t;
endpackage

// File: rtl/gpt_post_pipe.sv
`timescale 1ns/1ps
// Posted-write pipeline: each bus write travels STAGES registers before it is
// presented for commit. Assumes at most one write per cycle; never stalls.
module gpt_post_pipe
    import gpt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  post_wr_t wr_pkt,
    output logic     cm_valid,
    output post_wr_t cm_pkt,
    output logic     pending
);
    logic     vld [STAGES];
    post_wr_t pkt [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Move one write per cycle down the posting chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
                pkt[i] <= '0;
            end else if (i == 0) begin
                vld[i] <= wr_en;
                pkt[i] <= wr_pkt;
            end else begin
                vld[i] <= vld[i-1];
                pkt[i] <= pkt[i-1];
            end
        end
    end

    // Any write still in flight counts as pending.
    always_comb begin
        pending = 1'b0;
        for (int k = 0; k < STAGES; k++) pending = pending | vld[k];
    end

    assign cm_valid = vld[STAGES-1];
    assign cm_pkt   = pkt[STAGES-1];
endmodule

// File: rtl/gpt_prescale.sv
`timescale 1ns/1ps
// Tick divider: with the divider on, one step every 2^(div+1) ticks; with it
// off, one step per tick. Phase restarts whenever the timer is not running.
module gpt_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             pre_on,
    input  logic [PTV_W-1:0] div,
    output logic             step
);
    localparam int PC_W = 1 << PTV_W;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] limit;
    logic            wrap;

    // Terminal count is 2^(div+1)-1: the low div+1 bits set.
    always_comb begin
        limit = '0;
        for (int k = 0; k < PC_W; k++) limit[k] = (k <= int'(div));
    end

    assign wrap = (pcnt == limit);
    assign step = run & tick & (~pre_on | wrap);

    // Advance the divider phase on each tick while dividing.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else if (tick && pre_on) pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/gpt_counter.sv
`timescale 1ns/1ps
// Main up-counter with overflow and compare events. A direct set from the bus
// has priority over counting and suppresses that cycle's events.
module gpt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         auto_rl,
    input  logic         cmp_on,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] reload_val,
    input  logic         set_en,
    input  logic [W-1:0] set_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         match_evt
);
    logic         at_top;
    logic [W-1:0] cnt_inc;

    assign at_top    = &cnt;
    assign cnt_inc   = cnt + {{(W-1){1'b0}}, 1'b1};
    assign ovf_evt   = step & ~set_en & at_top;
    assign match_evt = step & ~set_en & ~at_top & cmp_on & (cnt_inc == cmp_val);

    // Load, reload or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (set_en) cnt <= set_val;
        else if (step)   cnt <= at_top ? (auto_rl ? reload_val : '0) : cnt_inc;
    end
endmodule

// File: rtl/gpt_capture.sv
`timescale 1ns/1ps
// Edge capture: detects the selected edge on a clk-synchronous input and
// copies the count. Hold mode keeps the first capture until acknowledged.
module gpt_capture
    import gpt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  edge_sel_e    edge_sel,
    input  logic         hold_mode,
    input  logic         flag_set,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_q,
    output logic         cap_evt
);
    logic prev;
    logic rise, fall;

    assign rise = cap_in & ~prev;
    assign fall = ~cap_in & prev;

    // Match the detected edge against the selection.
    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: cap_evt = rise;
            EDGE_FALL: cap_evt = fall;
            EDGE_BOTH: cap_evt = rise | fall;
            default:   cap_evt = 1'b0;
        endcase
    end

    // Remember the input and store the count on a selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= 1'b0;
            cap_q <= '0;
        end else begin
            prev <= cap_in;
            if (cap_evt && !(hold_mode && flag_set)) cap_q <= cnt;
        end
    end
endmodule

// File: rtl/gpt_wave.sv
`timescale 1ns/1ps
// Waveform generator: toggles or pulses on the selected counter events,
// with an output inversion applied after the state register.
module gpt_wave
    import gpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ovf_evt,
    input  logic      match_evt,
    input  wave_sel_e sel,
    input  logic      toggle,
    input  logic      invert,
    output logic      wave
);
    logic state;
    logic hit;

    // Pick which counter events drive the waveform.
    always_comb begin
        unique case (sel)
            WAVE_OVF:     hit = ovf_evt;
            WAVE_OVF_CMP: hit = ovf_evt | match_evt;
            default:      hit = 1'b0;
        endcase
    end

    // Flip on an event in toggle mode; follow the event in pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= 1'b0;
        else if (toggle) state <= state ^ hit;
        else             state <= hit;
    end

    assign wave = state ^ invert;
endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
// General-purpose timer top: posted register port, divider, counter, capture
// and waveform. Assumes cap_in and the bus are synchronous to clk.
module gp_timer
    import gpt_pkg::*;
#(
    parameter logic [BUS_W-1:0] ID_VALUE    = 32'h0002_0105,
    parameter int               PTV_W       = 3,
    parameter int               POST_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cap_in,
    output logic             pwm_out,
    output logic             irq_out
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] ien_q;
    logic [BUS_W-1:0]  reload_q;
    logic [BUS_W-1:0]  cmp_q;
    logic [BUS_W-1:0]  cnt;
    logic [BUS_W-1:0]  cap_q;

    post_wr_t    in_pkt, cm_pkt;
    logic        cm_valid, pending;
    logic        hit_ctrl, hit_stat, hit_ien, hit_reld, hit_cmp, hit_cnt, hit_trig;
    logic        step, ovf_evt, match_evt, cap_evt, set_en;
    logic [BUS_W-1:0] set_val;

    assign in_pkt = '{addr: bus_addr, data: bus_wdata};

    gpt_post_pipe #(.STAGES(POST_STAGES)) u_post (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_pkt(in_pkt),
        .cm_valid(cm_valid), .cm_pkt(cm_pkt), .pending(pending)
    );

    // Decode the committing write.
    always_comb begin
        hit_ctrl = cm_valid && (cm_pkt.addr == A_CTRL);
        hit_stat = cm_valid && (cm_pkt.addr == A_STAT);
        hit_ien  = cm_valid && (cm_pkt.addr == A_IEN);
        hit_reld = cm_valid && (cm_pkt.addr == A_RELD);
        hit_cmp  = cm_valid && (cm_pkt.addr == A_CMP);
        hit_cnt  = cm_valid && (cm_pkt.addr == A_COUNT);
        hit_trig = cm_valid && (cm_pkt.addr == A_TRIG);
    end

    assign set_en  = hit_cnt | hit_trig;
    assign set_val = hit_cnt ? cm_pkt.data : reload_q;

    gpt_prescale #(.PTV_W(PTV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_RUN]), .tick(tick_en),
        .pre_on(ctrl_q[B_PREN]), .div(ctrl_q[B_DIV +: PTV_W]), .step(step)
    );

    gpt_counter #(.W(BUS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .auto_rl(ctrl_q[B_ARL]),
        .cmp_on(ctrl_q[B_CMPE]), .cmp_val(cmp_q), .reload_val(reload_q),
        .set_en(set_en), .set_val(set_val), .cnt(cnt),
        .ovf_evt(ovf_evt), .match_evt(match_evt)
    );

    gpt_capture #(.W(BUS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .edge_sel(edge_sel_e'(ctrl_q[B_EDGE +: 2])), .hold_mode(ctrl_q[B_HOLD]),
        .flag_set(stat_q[S_CAPT]), .cnt(cnt), .cap_q(cap_q), .cap_evt(cap_evt)
    );

    gpt_wave u_wave (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .match_evt(match_evt),
        .sel(wave_sel_e'(ctrl_q[B_WEVT +: 2])), .toggle(ctrl_q[B_TGL]),
        .invert(ctrl_q[B_INV]), .wave(pwm_out)
    );

    // Control word: bus write wins; one-shot overflow drops the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (hit_ctrl)                   ctrl_q <= cm_pkt.data[CTRL_W-1:0];
        else if (ovf_evt && !ctrl_q[B_ARL])  ctrl_q[B_RUN] <= 1'b0;
    end

    // Value registers written only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q    <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
        end else begin
            if (hit_ien)  ien_q    <= cm_pkt.data[STAT_W-1:0];
            if (hit_reld) reload_q <= cm_pkt.data;
            if (hit_cmp)  cmp_q    <= cm_pkt.data;
        end
    end

    // Status flags: write-one-to-clear, with new events taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else stat_q <= (stat_q & ~(hit_stat ? cm_pkt.data[STAT_W-1:0] : '0))
                     | {cap_evt, ovf_evt, match_evt};
    end

    assign irq_out = |(stat_q & ien_q);

    // Combinational read mux over the implemented offsets.
    always_comb begin
        unique case (bus_addr)
            A_ID:    bus_rdata = ID_VALUE;
            A_STAT:  bus_rdata = {{(BUS_W-STAT_W){1'b0}}, stat_q};
            A_IEN:   bus_rdata = {{(BUS_W-STAT_W){1'b0}}, ien_q};
            A_CTRL:  bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
            A_COUNT: bus_rdata = cnt;
            A_RELD:  bus_rdata = reload_q;
            A_PEND:  bus_rdata = {{(BUS_W-1){1'b0}}, pending};
            A_CMP:   bus_rdata = cmp_q;
            A_CAPT:  bus_rdata = cap_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gp_timer_chk.sv
`timescale 1ns/1ps
// Property checker for gp_timer, attached by bind below.
module gp_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         tick_en,
    input logic         pending,
    input logic         cm_valid,
    input logic         run,
    input logic         auto_rl,
    input logic [W-1:0] cnt,
    input logic         ovf_evt,
    input logic         cap_evt,
    input logic [2:0]   stat
);
    // R2: a sampled write is visible as pending in the next cycle
    a_r2_post_pending: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> pending);

    // R3: stopped timer without a committing write keeps its count
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cm_valid) |=> $stable(cnt));

    // R3: no tick, no change
    a_r3_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cm_valid) |=> $stable(cnt));

    // R5: overflow raises its flag
    a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> stat[1]);

    // R5: one-shot overflow halts at zero
    a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !auto_rl && !cm_valid) |=> (!run && cnt == '0));

    // R9: a selected edge raises the capture flag
    a_r9_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> stat[2]);
endmodule

bind gp_timer gp_timer_chk #(.W(gpt_pkg::BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .tick_en(tick_en),
    .pending(pending), .cm_valid(cm_valid), .run(ctrl_q[0]),
    .auto_rl(ctrl_q[1]), .cnt(cnt), .ovf_evt(ovf_evt), .cap_evt(cap_evt),
    .stat(stat_q)
);

// File: tb/tb_gp_timer.sv
`timescale 1ns/1ps
module tb_gp_timer;
    localparam logic [31:0] IDV = 32'h0002_0105;

    logic        clk = 1'b0;
    logic        rst_n, tick_en, bus_wr, cap_in;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        pwm_out, irq_out;
    int          n_vec = 0;
    int          n_bad = 0;

    gp_timer #(.ID_VALUE(IDV)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .pwm_out(pwm_out), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    function automatic int unsigned div_ticks(input bit pre, input int p);
        return pre ? (32'd1 << (p + 1)) : 32'd1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Issue one write and return once it has committed.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int lim, output bit found);
        found = 1'b0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (irq_out) begin found = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        report();
    end

    initial begin
        logic [31:0] a, b, v, ld, m;
        bit f;
        void'($urandom(32'd9127));
        rst_n = 0; tick_en = 1; bus_wr = 0; cap_in = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 id", v, IDV);
        rd(8'h24, v); chk("R1 ctrl", v, 0);
        rd(8'h28, v); chk("R1 count", v, 0);
        rd(8'h18, v); chk("R1 status", v, 0);
        rd(8'h34, v); chk("R1 pending", v, 0);
        rd(8'h3C, v); chk("R1 capture", v, 0);
        chk("R1 irq", irq_out, 0);
        chk("R1 pwm", pwm_out, 0);

        // R2 posted write timing, R8 direct count write
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h28; bus_wdata = 32'h1234;
        @(negedge clk); bus_wr = 0;
        rd(8'h34, v); chk("R2 pending edge+0", v, 1);
        rd(8'h28, v); chk("R2 not yet applied", v, 0);
        @(negedge clk);
        rd(8'h34, v); chk("R2 pending edge+1", v, 1);
        rd(8'h28, v); chk("R2 not yet applied +1", v, 0);
        @(negedge clk);
        rd(8'h34, v); chk("R2 pending cleared", v, 0);
        rd(8'h28, v); chk("R8 count written", v, 32'h1234);

        // R3 counting, tick gating, stop
        wr(8'h24, 32'h1);
        rd(8'h28, a); repeat (20) @(negedge clk); rd(8'h28, b);
        chk("R3 twenty steps", b - a, 20);
        tick_en = 0;
        rd(8'h28, a); repeat (10) @(negedge clk); rd(8'h28, b);
        chk("R3 tick low holds", b, a);
        tick_en = 1;
        wr(8'h24, 32'h0);
        rd(8'h28, a); repeat (10) @(negedge clk); rd(8'h28, b);
        chk("R3 stopped holds", b, a);

        // R4 divider, random settings; R8 random count readback
        for (int i = 0; i < 8; i++) begin
            int  p;
            bit  pre;
            p   = int'($urandom_range(0, 3));
            pre = (i == 0) ? 1'b0 : 1'(i % 2 == 1 || i == 6);
            v   = $urandom_range(0, 32'h0FFF_FFFF);
            wr(8'h28, v);
            rd(8'h28, a); chk("R8 random count write", a, v);
            wr(8'h24, 32'h1 | (32'(pre) << 5) | (32'(p) << 2));
            rd(8'h28, a);
            repeat (4 * div_ticks(pre, p)) @(negedge clk);
            rd(8'h28, b);
            chk("R4 divided step count", b - a, 4);
            wr(8'h24, 32'h0);
        end

        // R5 auto-reload overflow, R11 inverted pulse on overflow
        ld = $urandom_range(32'h100, 32'hFFFF);
        wr(8'h1C, 32'h2);
        wr(8'h2C, ld);
        wr(8'h28, 32'hFFFF_FFF0);
        wr(8'h24, 32'h3 | (32'h1 << 10) | (32'h1 << 12));
        chk("R11 inverted idle", pwm_out, 1);
        wait_irq(100, f);
        chk("R5 overflow irq seen", 32'(f), 1);
        rd(8'h28, v); chk("R5 reloaded", v, ld);
        rd(8'h18, v); chk("R5 ovf flag", v, 32'h2);
        chk("R11 pulse active", pwm_out, 0);
        @(negedge clk);
        chk("R11 pulse one cycle", pwm_out, 1);
        wr(8'h24, 32'h0);
        wr(8'h18, 32'h7);
        chk("R7 irq cleared", irq_out, 0);

        // R5 one-shot overflow, R11 toggle on overflow
        wr(8'h28, 32'hFFFF_FFF8);
        wr(8'h24, 32'h1 | (32'h1 << 7) | (32'h1 << 10));
        chk("R11 toggle idle", pwm_out, 0);
        wait_irq(100, f);
        chk("R5 one-shot irq seen", 32'(f), 1);
        rd(8'h28, v); chk("R5 one-shot zero", v, 0);
        rd(8'h24, v); chk("R5 run cleared", v, (32'h1 << 7) | (32'h1 << 10));
        chk("R11 toggled on overflow", pwm_out, 1);
        repeat (5) @(negedge clk);
        rd(8'h28, v); chk("R5 stays halted", v, 0);
        wr(8'h18, 32'h7);

        // R6 compare match, R11 toggle on match
        m = $urandom_range(20, 200);
        wr(8'h1C, 32'h1);
        wr(8'h38, m);
        wr(8'h28, 32'h0);
        wr(8'h24, 32'h1 | (32'h1 << 6) | (32'h1 << 7) | (32'h2 << 10));
        wait_irq(400, f);
        chk("R6 match irq seen", 32'(f), 1);
        rd(8'h28, v); chk("R6 count at match", v, m);
        chk("R11 toggled on match", pwm_out, 0);
        wr(8'h24, 32'h0);

        // R7 write-zero, enable mask, write-one clear
        wr(8'h18, 32'h0);
        rd(8'h18, v); chk("R7 write zero keeps", v, 32'h1);
        wr(8'h1C, 32'h6);
        chk("R7 masked irq", irq_out, 0);
        wr(8'h1C, 32'h1);
        chk("R7 enabled irq", irq_out, 1);
        wr(8'h18, 32'h1);
        rd(8'h18, v); chk("R7 cleared", v, 0);
        chk("R7 irq low", irq_out, 0);

        // R6 compare disabled raises nothing
        wr(8'h28, 32'h0);
        wr(8'h24, 32'h1);
        repeat (m + 10) @(negedge clk);
        rd(8'h18, v); chk("R6 compare off", v, 0);
        wr(8'h24, 32'h0);

        // R8 trigger reload
        ld = $urandom();
        wr(8'h2C, ld);
        wr(8'h28, 32'h5);
        wr(8'h24, 32'h1);
        wr(8'h30, $urandom());
        rd(8'h28, v); chk("R8 trigger reload", v, ld);
        wr(8'h24, 32'h0);

        // R9 capture edges, R10 hold mode
        wr(8'h18, 32'h7);
        wr(8'h28, 32'hA5A5_0001);
        wr(8'h24, 32'h1 << 8);
        @(negedge clk); cap_in = 1; @(negedge clk);
        rd(8'h3C, v); chk("R9 rising capture", v, 32'hA5A5_0001);
        rd(8'h18, v); chk("R9 capture flag", v, 32'h4);
        wr(8'h18, 32'h4);
        @(negedge clk); cap_in = 0; @(negedge clk);
        rd(8'h18, v); chk("R9 falling ignored", v, 0);
        wr(8'h28, 32'hA5A5_0002);
        wr(8'h24, (32'h1 << 13) | (32'h3 << 8));
        @(negedge clk); cap_in = 1; @(negedge clk);
        rd(8'h3C, v); chk("R9 both-edge capture", v, 32'hA5A5_0002);
        wr(8'h28, 32'hA5A5_0003);
        @(negedge clk); cap_in = 0; @(negedge clk);
        rd(8'h3C, v); chk("R10 hold keeps first", v, 32'hA5A5_0002);
        rd(8'h18, v); chk("R10 flag still set", v, 32'h4);
        wr(8'h24, 32'h2 << 8);
        wr(8'h18, 32'h4);
        @(negedge clk); cap_in = 1; @(negedge clk);
        rd(8'h18, v); chk("R9 rising ignored", v, 0);
        @(negedge clk); cap_in = 0; @(negedge clk);
        rd(8'h3C, v); chk("R10 overwrite mode", v, 32'hA5A5_0003);

        report();
    end
endmodule